// File: doc/BRIEF.md
# Eight-bit ALU status flag unit

This block pairs an 8-bit adder and logic unit with the status byte that records what the last operation produced. The caller presents two operands and an operation code, then pulses a result-valid strobe. On the next clock edge the block registers the result and refreshes the arithmetic flags: carry, zero, negative, two's complement overflow, sign and half carry. Two further bits sit in the same byte and are never touched by arithmetic. The first is a single-bit scratch copy that is loaded through its own control. The second is a global interrupt enable that has separate set and clear inputs.

The operations that take a carry use the stored carry flag as their carry or borrow input. This lets multi-byte additions and subtractions be chained one byte at a time. Instruction decode, the register file and interrupt dispatch sit outside this block.

Top module: `alu_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears `result` and every bit of `flags` to zero.
- R2: `op_sel` encodes 0 = add, 1 = add with carry, 2 = subtract (A minus B), 3 = subtract with borrow, 4 = AND, 5 = OR, 6 = XOR. Code 7 is reserved: a strobed code 7 leaves `result` and all flags unchanged.
- R3: Flag bit 0 (carry) is set after an add that carries out of bit 7, and after a subtract that needs a borrow (unsigned A is less than B plus the borrow in).
- R4: Flag bit 1 (zero) is set exactly when the new 8-bit result is 0x00. Flag bit 2 (negative) equals bit 7 of the new result.
- R5: Flag bit 3 (overflow) is set when an add of two same-sign operands, or a subtract of opposite-sign operands, gives a result whose sign differs from A. Logical operations clear it.
- R6: Flag bit 4 (sign) always equals bit 2 XOR bit 3.
- R7: Flag bit 5 (half carry) is set on a carry out of bit 3 in an add, or a borrow into bit 3 from bit 4 in a subtract.
- R8: Add with carry adds the stored carry flag. Subtract with borrow also subtracts the stored carry flag.
- R9: AND, OR and XOR leave the carry and half-carry flags unchanged.
- R10: While `alu_valid` is low, `result` and flag bits 0 to 5 hold, whatever the operand inputs do.
- R11: Flag bit 6 takes `t_din` on the edge where `t_load` is high and holds otherwise. ALU operations never change it.
- R12: Flag bit 7 is cleared by `i_clr`, set by `i_set`, and holds otherwise. Clear wins when both are high. ALU operations never change it.
- R13: An ALU strobe, a `t_load` and an `i_set`/`i_clr` in the same cycle all take effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 8 | First operand (minuend for subtracts) |
| op_b | input | 8 | Second operand |
| op_sel | input | 3 | Operation code (see R2) |
| alu_valid | input | 1 | Result-valid strobe; registers result and arithmetic flags |
| t_load | input | 1 | Load the bit-copy flag from `t_din` |
| t_din | input | 1 | Value for the bit-copy flag |
| i_set | input | 1 | Set the interrupt-enable flag |
| i_clr | input | 1 | Clear the interrupt-enable flag (has priority) |
| result | output | 8 | Registered ALU result |
| flags | output | 8 | Status byte: bit0 C, 1 Z, 2 N, 3 V, 4 S, 5 H, 6 T, 7 I |

## Verification
An ALU strobe can land in the same cycle as a bit-copy load or an interrupt-enable set or clear. Each of these writes a different part of the status byte on one edge. The bench provokes the overlap with directed cycles that raise `alu_valid` together with `t_load` and `i_set`, and with `i_set` and `i_clr` together. It then keeps the controls random during a long run of random operations. Each registered byte is judged against a bench model that applies the arithmetic update and the T and I rules independently. The model also follows the clear-over-set priority.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBC = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_RSVD = 3'd7
  } alu_op_e;

  // status byte, MSB first: interrupt enable, bit copy, half, sign, ovf, neg, zero, carry
  typedef struct packed {
    logic i;
    logic t;
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  localparam int FLAG_W  = 8;
  localparam int ARITH_W = 6;

  localparam int FB_C = 0;
  localparam int FB_Z = 1;
  localparam int FB_N = 2;
  localparam int FB_V = 3;
  localparam int FB_S = 4;
  localparam int FB_H = 5;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W  = 8,
  parameter int HB = W / 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         use_c,
  input  logic         c_flag,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);

  logic [W:0]   cy;
  logic [W-1:0] bx;

  // subtract as a + ~b + 1, with the stored carry acting as a borrow
  assign bx    = sub ? ~b : b;
  assign cy[0] = sub ^ (use_c & c_flag);

  generate
    for (genvar i = 0; i < W; i++) begin : g_fa
      assign sum[i]  = a[i] ^ bx[i] ^ cy[i];
      assign cy[i+1] = (a[i] & bx[i]) | (cy[i] & (a[i] ^ bx[i]));
    end
  endgenerate

  // borrow is the inverted carry for subtraction
  assign c_out = cy[W]  ^ sub;
  assign h_out = cy[HB] ^ sub;
  assign v_out = cy[W]  ^ cy[W-1];

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res
);

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/flag_next.sv
module flag_next
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e            op,
  input  logic               cur_c,
  input  logic               cur_h,
  input  logic [W-1:0]       add_sum,
  input  logic               add_c,
  input  logic               add_h,
  input  logic               add_v,
  input  logic [W-1:0]       log_res,
  output logic               upd,
  output logic [W-1:0]       res_nxt,
  output logic [ARITH_W-1:0] flg_nxt
);

  logic is_arith;
  logic is_logic;

  assign is_arith = (op == OP_ADD) || (op == OP_ADDC) ||
                    (op == OP_SUB) || (op == OP_SUBC);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign upd      = is_arith | is_logic;

  always_comb begin
    res_nxt = is_arith ? add_sum : log_res;
    flg_nxt = '0;
    flg_nxt[FB_Z] = (res_nxt == '0);
    flg_nxt[FB_N] = res_nxt[W-1];
    if (is_arith) begin
      flg_nxt[FB_C] = add_c;
      flg_nxt[FB_H] = add_h;
      flg_nxt[FB_V] = add_v;
    end else begin
      flg_nxt[FB_C] = cur_c;
      flg_nxt[FB_H] = cur_h;
      flg_nxt[FB_V] = 1'b0;
    end
    flg_nxt[FB_S] = flg_nxt[FB_N] ^ flg_nxt[FB_V];
  end

endmodule

// File: rtl/status_reg.sv
module status_reg
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alu_fire,
  input  logic [W-1:0]       res_nxt,
  input  logic [ARITH_W-1:0] flg_nxt,
  input  logic               t_load,
  input  logic               t_din,
  input  logic               i_set,
  input  logic               i_clr,
  output logic [W-1:0]       result_q,
  output flags_t             flags_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      flags_q.c <= 1'b0;
      flags_q.z <= 1'b0;
      flags_q.n <= 1'b0;
      flags_q.v <= 1'b0;
      flags_q.s <= 1'b0;
      flags_q.h <= 1'b0;
    end else if (alu_fire) begin
      result_q  <= res_nxt;
      flags_q.c <= flg_nxt[FB_C];
      flags_q.z <= flg_nxt[FB_Z];
      flags_q.n <= flg_nxt[FB_N];
      flags_q.v <= flg_nxt[FB_V];
      flags_q.s <= flg_nxt[FB_S];
      flags_q.h <= flg_nxt[FB_H];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q.t <= 1'b0;
    end else if (t_load) begin
      flags_q.t <= t_din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q.i <= 1'b0;
    end else if (i_clr) begin
      flags_q.i <= 1'b0;
    end else if (i_set) begin
      flags_q.i <= 1'b1;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !alu_fire |=> ($stable(result_q) && $stable(flags_q[ARITH_W-1:0])));

  p_sign_r6: assert property (@(posedge clk) disable iff (rst)
    flags_q.s == (flags_q.n ^ flags_q.v));

  p_tkeep_r11: assert property (@(posedge clk) disable iff (rst)
    !t_load |=> $stable(flags_q.t));

  p_tload_r13: assert property (@(posedge clk) disable iff (rst)
    t_load |=> (flags_q.t == $past(t_din)));

  p_iclr_r12: assert property (@(posedge clk) disable iff (rst)
    i_clr |=> !flags_q.i);

  p_iset_r12: assert property (@(posedge clk) disable iff (rst)
    (i_set && !i_clr) |=> flags_q.i);

  p_ikeep_r12: assert property (@(posedge clk) disable iff (rst)
    (!i_set && !i_clr) |=> $stable(flags_q.i));

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [2:0]        op_sel,
  input  logic              alu_valid,
  input  logic              t_load,
  input  logic              t_din,
  input  logic              i_set,
  input  logic              i_clr,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flags
);

  localparam int HALF_BIT = DATA_W / 2;

  alu_op_e            op;
  flags_t             flags_q;
  logic [DATA_W-1:0]  add_sum;
  logic               add_c;
  logic               add_h;
  logic               add_v;
  logic [DATA_W-1:0]  log_res;
  logic               upd;
  logic [DATA_W-1:0]  res_nxt;
  logic [ARITH_W-1:0] flg_nxt;
  logic               is_sub;
  logic               with_c;

  assign op     = alu_op_e'(op_sel);
  assign is_sub = (op == OP_SUB)  || (op == OP_SUBC);
  assign with_c = (op == OP_ADDC) || (op == OP_SUBC);

  alu_adder #(.W(DATA_W), .HB(HALF_BIT)) u_adder (
    .a      (op_a),
    .b      (op_b),
    .sub    (is_sub),
    .use_c  (with_c),
    .c_flag (flags_q.c),
    .sum    (add_sum),
    .c_out  (add_c),
    .h_out  (add_h),
    .v_out  (add_v)
  );

  alu_logic #(.W(DATA_W)) u_logic (
    .a   (op_a),
    .b   (op_b),
    .op  (op),
    .res (log_res)
  );

  flag_next #(.W(DATA_W)) u_next (
    .op      (op),
    .cur_c   (flags_q.c),
    .cur_h   (flags_q.h),
    .add_sum (add_sum),
    .add_c   (add_c),
    .add_h   (add_h),
    .add_v   (add_v),
    .log_res (log_res),
    .upd     (upd),
    .res_nxt (res_nxt),
    .flg_nxt (flg_nxt)
  );

  status_reg #(.W(DATA_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .alu_fire (alu_valid & upd),
    .res_nxt  (res_nxt),
    .flg_nxt  (flg_nxt),
    .t_load   (t_load),
    .t_din    (t_din),
    .i_set    (i_set),
    .i_clr    (i_clr),
    .result_q (result),
    .flags_q  (flags_q)
  );

  assign flags = flags_q;

  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && op_sel != 3'd7) |=> (flags[FB_Z] == (result == '0)));

  p_neg_r4: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && op_sel != 3'd7) |=> (flags[FB_N] == result[DATA_W-1]));

  p_logic_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && op_sel >= 3'd4 && op_sel <= 3'd6) |=>
      (flags[FB_C] == $past(flags[FB_C]) && flags[FB_H] == $past(flags[FB_H])));

  p_logic_v_r5: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && op_sel >= 3'd4 && op_sel <= 3'd6) |=> !flags[FB_V]);

  p_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && op_sel == 3'd7) |=>
      ($stable(result) && flags[ARITH_W-1:0] == $past(flags[ARITH_W-1:0])));

endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;

  typedef struct {
    logic [7:0] res;
    logic [7:0] flg;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_a = '0;
  logic [7:0] op_b = '0;
  logic [2:0] op_sel = '0;
  logic       alu_valid = 1'b0;
  logic       t_load = 1'b0;
  logic       t_din = 1'b0;
  logic       i_set = 1'b0;
  logic       i_clr = 1'b0;
  logic [7:0] result;
  logic [7:0] flags;

  int    checks = 0;
  int    fails  = 0;
  int    prev_sz = 0;
  bit    done = 1'b0;
  item_t sb_q[$];

  logic [7:0] m_res = '0;
  logic [7:0] m_flg = '0;

  always #5 clk = ~clk;

  alu_flag_unit u_dut (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .alu_valid (alu_valid),
    .t_load    (t_load),
    .t_din     (t_din),
    .i_set     (i_set),
    .i_clr     (i_clr),
    .result    (result),
    .flags     (flags)
  );

  // independent model of the requirements
  task automatic model(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op,
                       input logic v, input logic tl, input logic td,
                       input logic is, input logic ic);
    int ci, ua, ub, sa, sb, r, sr;
    logic [7:0] rb;
    if (v && op != 3'd7) begin
      ua = a; ub = b;
      sa = (ua > 127) ? ua - 256 : ua;
      sb = (ub > 127) ? ub - 256 : ub;
      ci = (op == 3'd1 || op == 3'd3) ? int'(m_flg[0]) : 0;
      if (op <= 3'd1) begin
        r  = ua + ub + ci;
        sr = sa + sb + ci;
        rb = r[7:0];
        m_flg[0] = (r > 255);
        m_flg[5] = ((ua % 16) + (ub % 16) + ci) > 15;
        m_flg[3] = (sr > 127) || (sr < -128);
      end else if (op <= 3'd3) begin
        r  = ua - ub - ci;
        sr = sa - sb - ci;
        rb = r[7:0];
        m_flg[0] = (r < 0);
        m_flg[5] = ((ua % 16) - (ub % 16) - ci) < 0;
        m_flg[3] = (sr > 127) || (sr < -128);
      end else begin
        if (op == 3'd4)      rb = a & b;
        else if (op == 3'd5) rb = a | b;
        else                 rb = a ^ b;
        m_flg[3] = 1'b0;
      end
      m_res    = rb;
      m_flg[1] = (rb == 8'h00);
      m_flg[2] = rb[7];
      m_flg[4] = m_flg[2] ^ m_flg[3];
    end
    if (tl) m_flg[6] = td;
    if (ic) m_flg[7] = 1'b0;
    else if (is) m_flg[7] = 1'b1;
  endtask

  // driver: one cycle per call, expected item pushed to the scoreboard
  task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op,
                       input logic v, input logic tl, input logic td,
                       input logic is, input logic ic, input string tag);
    item_t it;
    @(posedge clk);
    #2;
    op_a = a; op_b = b; op_sel = op; alu_valid = v;
    t_load = tl; t_din = td; i_set = is; i_clr = ic;
    model(a, b, op, v, tl, td, is, ic);
    it.res = m_res; it.flg = m_flg; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic alu(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op,
                     input string tag);
    drive(a, b, op, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor: compares the item whose inputs were captured at the last edge
  always @(negedge clk) begin
    if (!rst && prev_sz > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (result !== it.res || flags !== it.flg) begin
        fails++;
        $display("FAIL %s: actual res=%02h flags=%08b expected res=%02h flags=%08b",
                 it.tag, result, flags, it.res, it.flg);
      end
    end
    prev_sz = sb_q.size();
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    op_a = 8'hFF; op_b = 8'hFF; alu_valid = 1'b1; i_set = 1'b1; t_load = 1'b1; t_din = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    op_a = '0; op_b = '0; alu_valid = 1'b0; i_set = 1'b0; t_load = 1'b0; t_din = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (result !== 8'h00 || flags !== 8'h00) begin
      fails++;
      $display("FAIL R1 reset: actual res=%02h flags=%08b expected res=00 flags=00000000",
               result, flags);
    end

    alu(8'd110, 8'd227, 3'd0, "R3 R7 add 110+227");
    alu(8'd55,  8'd80,  3'd1, "R8 R5 addc with carry set");
    alu(8'd128, 8'd128, 3'd0, "R4 R5 R6 add 128+128");
    alu(8'd5,   8'd10,  3'd2, "R3 R7 sub borrow");
    alu(8'h10,  8'h0F,  3'd3, "R8 R4 subc with borrow");
    alu(8'h7F,  8'hFF,  3'd2, "R5 sub overflow");
    alu(8'hF0,  8'h3C,  3'd4, "R9 R2 and keeps C H");
    alu(8'hF0,  8'h0F,  3'd5, "R9 R2 or");
    alu(8'hAA,  8'hAA,  3'd6, "R9 R4 xor zero");
    alu(8'h0F,  8'h01,  3'd0, "R7 half carry only");
    alu(8'h33,  8'h44,  3'd7, "R2 reserved code holds");
    drive(8'h99, 8'h11, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 no strobe holds");
    drive(8'hFF, 8'h01, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 no strobe holds 2");
    drive(8'h00, 8'h00, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R11 t load one");
    alu(8'h01,  8'hFF,  3'd0, "R11 alu keeps T");
    drive(8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R12 i set");
    alu(8'h80,  8'h01,  3'd2, "R12 alu keeps I");
    drive(8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R12 clear wins");
    drive(8'h7F, 8'h01, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R13 alu T I same cycle");
    drive(8'h40, 8'h40, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R13 alu T clr same cycle");

    for (int k = 0; k < 400; k++) begin
      drive(8'($urandom), 8'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), "R2 R3 R6 R13 random");
    end

    drive(8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 idle");
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule